// File: doc/BRIEF.md
# Wrap-Around Loopback Self-Test Controller

This block supervises the wrap-around self-test of a serial-bus terminal that can act either as bus controller (BC) or as remote terminal (RT). On every message it captures the last word handed to the encoder. It then waits for the decoder to deliver that word back, either through the transceivers or through an internal path. It compares the two and reports the result. Manchester coding is handled elsewhere. The block only sees the parallel transmit word, the decoded word with its valid and error qualifiers, and a memory write port.

When the terminal is a BC, the word received back is written to memory one location past the last word of the message block, so software can compare the two. When the terminal is an RT, a failure raises the terminal flag that goes into the outgoing status word. In both roles a failure raises the loop-fail flag of the block status word. Software can also ask for an off-line test in BC role. The transceivers are then inhibited for that message and the encoder output is looped straight into the decoder.

Top module: `loopback_selftest`

## Requirements
- R1: After reset, every output (`xcvr_inhibit_o`, `loop_route_o`, `mem_we_o`, `mem_addr_o`, `mem_wdata_o`, `loop_fail_o`, `term_flag_o`) is 0.
- R2: A message start with `offline_req_i`=1 and `mode_bc_i`=1 raises `xcvr_inhibit_o` and `loop_route_o` from the next cycle until the check of that message completes. With `mode_bc_i`=0 the request is ignored and both stay 0.
- R3: In BC role, when the decoder returns the word with `rx_valid_i`=1, `mem_we_o` pulses for exactly one cycle, starting the cycle after the returning word is sampled. The pulse carries `mem_addr_o` = captured last-word address + 1 and `mem_wdata_o` = the received word. A matching word without a decode error leaves `loop_fail_o` at 0.
- R4: A received 16-bit value that differs from the captured last word sets `loop_fail_o`. In BC role the received value is still written back.
- R5: A returning word with `rx_err_i`=1 sets `loop_fail_o`, even if its value matches.
- R6: If no valid word returns, `loop_fail_o` rises exactly TIMEOUT_CYC clock edges after the edge that captured the last word, and no memory write occurs.
- R7: In RT role no memory write ever occurs, and every failure also sets `term_flag_o`.
- R8: In BC role `term_flag_o` stays 0.
- R9: `loop_fail_o` and `term_flag_o`, once set, hold until the next `msg_start_i`, which clears both on the following cycle.
- R10: Decoder words that arrive while no check is pending have no effect on the memory port or the flags.
- R11: The write-back address wraps modulo 2^AW, so a last word at the top address is followed by a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_bc_i | input | 1 | 1 = BC role, 0 = RT role; sampled at message start |
| offline_req_i | input | 1 | Off-line test request from the BC control word; sampled at message start |
| msg_start_i | input | 1 | One-cycle pulse at the start of each message |
| tx_valid_i | input | 1 | Encoder accepts a word this cycle |
| tx_last_i | input | 1 | That word is the last of the message |
| tx_word_i | input | W | Word handed to the encoder |
| tx_addr_i | input | AW | Memory address the transmitted word came from |
| rx_valid_i | input | 1 | Decoder delivers a word this cycle |
| rx_err_i | input | 1 | Decoder reports an error on that word |
| rx_word_i | input | W | Decoded word |
| xcvr_inhibit_o | output | 1 | Inhibit bus transceivers (off-line test) |
| loop_route_o | output | 1 | Route encoder output into decoder (off-line test) |
| mem_we_o | output | 1 | Write strobe for the loop-back word |
| mem_addr_o | output | AW | Write-back address |
| mem_wdata_o | output | W | Loop-back word written |
| loop_fail_o | output | 1 | Loop-test-fail bit of the block status word |
| term_flag_o | output | 1 | Terminal flag for the RT status word |

## Verification
A wrong captured address or word shows up on the first BC write-back, on the cycle after the returning word, as a bad address or data value. It can also show up as a spurious failure flag at that same edge. A miscounting timeout timer moves the rise of `loop_fail_o` away from the exact edge the bench checks. A stuck pending state shows up either as a write triggered by a stray decoder word or as an inhibit that never drops. Flags that are not cleared show up one cycle after the next message start.

// File: rtl/lt_pkg.sv
package lt_pkg;
   typedef enum logic {
      LT_IDLE = 1'b0,
      LT_WAIT = 1'b1
   } lt_state_e;
endpackage

// File: rtl/lt_word_cmp.sv
module lt_word_cmp #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         differ_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lt_word_cmp: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] bit_diff;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign bit_diff[b] = a_i[b] ^ b_i[b];
   end

   assign differ_o = |bit_diff;
endmodule

// File: rtl/lt_timeout.sv
module lt_timeout #(
   parameter int LIMIT = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic clr_i,
   output logic expire_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("lt_timeout: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = run_i && !clr_i && (cnt_q == LAST);

   AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);  // R6
   AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_q == '0);  // R6
endmodule

// File: rtl/loopback_selftest.sv
module loopback_selftest
   import lt_pkg::*;
#(
   parameter int W           = 16,
   parameter int AW          = 12,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          mode_bc_i,
   input  logic          offline_req_i,
   input  logic          msg_start_i,
   input  logic          tx_valid_i,
   input  logic          tx_last_i,
   input  logic [W-1:0]  tx_word_i,
   input  logic [AW-1:0] tx_addr_i,
   input  logic          rx_valid_i,
   input  logic          rx_err_i,
   input  logic [W-1:0]  rx_word_i,
   output logic          xcvr_inhibit_o,
   output logic          loop_route_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [W-1:0]  mem_wdata_o,
   output logic          loop_fail_o,
   output logic          term_flag_o
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("loopback_selftest: AW must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_to
         $error("loopback_selftest: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   lt_state_e     state_q;
   logic [W-1:0]  exp_word_q;
   logic [AW-1:0] wb_addr_q;
   logic          bc_q;
   logic          offl_q;
   logic          word_differ;
   logic          expired;
   logic          pending;
   logic          bad_word;

   assign pending  = (state_q == LT_WAIT) && !msg_start_i;
   assign bad_word = rx_err_i || word_differ;

   lt_word_cmp #(.W(W)) cmp_i (
      .a_i      (exp_word_q),
      .b_i      (rx_word_i),
      .differ_o (word_differ)
   );

   lt_timeout #(.LIMIT(TIMEOUT_CYC)) tmo_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (pending && !rx_valid_i),
      .clr_i    (state_q != LT_WAIT || msg_start_i),
      .expire_o (expired)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= LT_IDLE;
         exp_word_q  <= '0;
         wb_addr_q   <= '0;
         bc_q        <= 1'b0;
         offl_q      <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
         loop_fail_o <= 1'b0;
         term_flag_o <= 1'b0;
      end else begin
         mem_we_o <= 1'b0;
         if (msg_start_i) begin
            state_q     <= LT_IDLE;
            bc_q        <= mode_bc_i;
            offl_q      <= mode_bc_i && offline_req_i;
            loop_fail_o <= 1'b0;
            term_flag_o <= 1'b0;
         end else begin
            unique case (state_q)
               LT_IDLE: begin
                  if (tx_valid_i && tx_last_i) begin
                     exp_word_q <= tx_word_i;
                     wb_addr_q  <= tx_addr_i + 1'b1;
                     state_q    <= LT_WAIT;
                  end
               end
               LT_WAIT: begin
                  if (rx_valid_i) begin
                     if (bc_q) begin
                        mem_we_o    <= 1'b1;
                        mem_addr_o  <= wb_addr_q;
                        mem_wdata_o <= rx_word_i;
                     end
                     if (bad_word) begin
                        loop_fail_o <= 1'b1;
                        term_flag_o <= !bc_q;
                     end
                     state_q <= LT_IDLE;
                     offl_q  <= 1'b0;
                  end else if (expired) begin
                     loop_fail_o <= 1'b1;
                     term_flag_o <= !bc_q;
                     state_q     <= LT_IDLE;
                     offl_q      <= 1'b0;
                  end
               end
               default: state_q <= LT_IDLE;
            endcase
         end
      end
   end

   assign xcvr_inhibit_o = offl_q;
   assign loop_route_o   = offl_q;

   AST_INHIBIT_BC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xcvr_inhibit_o |-> bc_q);  // R2
   AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |=> !mem_we_o);  // R3
   AST_WE_NOT_RT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> bc_q);  // R7
   AST_TERM_NOT_BC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_flag_o |-> !bc_q);  // R8
   AST_TERM_IMPLIES_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_flag_o |-> loop_fail_o);  // R7
   AST_FLAGS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msg_start_i |=> (!loop_fail_o && !term_flag_o));  // R9
   AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_fail_o && !msg_start_i) |=> loop_fail_o);  // R9
   AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LT_IDLE) |=> !mem_we_o);  // R10
endmodule

// File: tb/loopback_selftest_tb_top.sv
module loopback_selftest_tb_top;
   localparam int W   = 16;
   localparam int AW  = 12;
   localparam int TMO = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_bc = 1'b0, offline_req = 1'b0, msg_start = 1'b0;
   logic          tx_valid = 1'b0, tx_last = 1'b0;
   logic [W-1:0]  tx_word = '0;
   logic [AW-1:0] tx_addr = '0;
   logic          rx_valid = 1'b0, rx_err = 1'b0;
   logic [W-1:0]  rx_word = '0;
   logic          inhibit, route, we, fail, term;
   logic [AW-1:0] waddr;
   logic [W-1:0]  wdata;

   int checks = 0;
   int failures = 0;
   logic [AW+W-1:0] exp_q[$];

   always #4 clk = ~clk;  // 125 MHz

   loopback_selftest #(.W(W), .AW(AW), .TIMEOUT_CYC(TMO)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_bc_i(mode_bc), .offline_req_i(offline_req),
      .msg_start_i(msg_start), .tx_valid_i(tx_valid), .tx_last_i(tx_last),
      .tx_word_i(tx_word), .tx_addr_i(tx_addr), .rx_valid_i(rx_valid),
      .rx_err_i(rx_err), .rx_word_i(rx_word), .xcvr_inhibit_o(inhibit),
      .loop_route_o(route), .mem_we_o(we), .mem_addr_o(waddr), .mem_wdata_o(wdata),
      .loop_fail_o(fail), .term_flag_o(term)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected write-backs as the design produces them (R3 R4 R7 R11)
   always @(negedge clk) begin
      if (rst_n && we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7/R10 unexpected write", {waddr, wdata}, 0);
         end else begin
            logic [AW+W-1:0] e;
            e = exp_q.pop_front();
            chk({waddr, wdata} == e, "R3/R11 write-back addr,data", {waddr, wdata}, e);
         end
      end
   end

   // Driver: one message; send_rx=0 exercises the timeout path
   task automatic run_msg(input bit bc, input bit offl, input logic [W-1:0] txw,
                          input logic [AW-1:0] adr, input logic [W-1:0] rxw,
                          input bit rxe, input int dly, input bit send_rx);
      bit exp_fail;
      exp_fail = !send_rx || rxe || (rxw != txw);
      mode_bc = bc; offline_req = offl; msg_start = 1'b1;
      @(negedge clk);
      msg_start = 1'b0;
      chk(fail == 1'b0 && term == 1'b0, "R9 flags cleared by start", {fail, term}, 0);
      chk(inhibit == (bc && offl) && route == (bc && offl), "R2 offline routing",
          {inhibit, route}, {2{bc && offl}});
      tx_valid = 1'b1; tx_last = 1'b1; tx_word = txw; tx_addr = adr;
      @(negedge clk);
      tx_valid = 1'b0; tx_last = 1'b0;
      if (send_rx) begin
         if (bc) exp_q.push_back({adr + 1'b1, rxw});
         repeat (dly) @(negedge clk);
         rx_valid = 1'b1; rx_word = rxw; rx_err = rxe;
         @(negedge clk);
         rx_valid = 1'b0; rx_err = 1'b0;
      end else begin
         repeat (TMO - 1) @(negedge clk);
         chk(fail == 1'b0, "R6 no failure before timeout", fail, 0);
         @(negedge clk);
      end
      chk(fail == exp_fail, "R4/R5/R6 loop fail flag", fail, exp_fail);
      chk(term == (exp_fail && !bc), "R7/R8 terminal flag", term, exp_fail && !bc);
      chk(inhibit == 1'b0, "R2 inhibit released after check", inhibit, 0);
      repeat (3) @(negedge clk);
      chk(fail == exp_fail, "R9 flag holds", fail, exp_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({inhibit, route, we, waddr, wdata, fail, term} == '0, "R1 reset state",
          {inhibit, route, we, waddr, wdata, fail, term}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_msg(1, 0, 16'hA5A5, 12'h010, 16'hA5A5, 0, 2, 1);   // R3 match
      run_msg(1, 0, 16'h1234, 12'h020, 16'h1236, 0, 0, 1);   // R4 mismatch, R8
      run_msg(1, 0, 16'h0F0F, 12'h030, 16'h0F0F, 1, 1, 1);   // R5 decode error
      run_msg(1, 0, 16'h7777, 12'h040, 16'h0000, 0, 0, 0);   // R6 timeout
      run_msg(0, 0, 16'hBEEF, 12'h050, 16'hBEEF, 0, 3, 1);   // R7 RT pass
      run_msg(0, 0, 16'hBEEF, 12'h060, 16'hBEEE, 0, 1, 1);   // R7 RT mismatch
      run_msg(0, 0, 16'h5555, 12'h070, 16'h5555, 0, 0, 0);   // R7 RT timeout
      run_msg(1, 1, 16'hC3C3, 12'h080, 16'hC3C3, 0, 4, 1);   // R2 offline BC
      run_msg(0, 1, 16'h3C3C, 12'h090, 16'h3C3C, 0, 1, 1);   // R2 ignored in RT
      run_msg(1, 0, 16'h8001, 12'hFFF, 16'h8001, 0, 0, 1);   // R11 wrap to 0
      // R10: stray decoder words while idle
      rx_valid = 1'b1; rx_word = 16'hDEAD; rx_err = 1'b1;
      repeat (3) @(negedge clk);
      rx_valid = 1'b0; rx_err = 1'b0;
      @(negedge clk);
      chk(we == 1'b0 && fail == 1'b0, "R10 idle rx ignored", {we, fail}, 0);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all write-backs seen", exp_q.size(), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule